// File: doc/BRIEF.md
# Display Window Update Sequencer

This block turns a rectangular screen update into the byte stream a display controller expects. A request carries a rectangle as inclusive start and exclusive end coordinates. The block sends three commands in a fixed order: set the column window, set the row window, and start the frame memory write. It then sends the rectangle's pixels as 16-bit RGB565 words, two bytes per pixel. Every output byte has a data/command flag, so a serial link downstream can frame it, either with a separate D/C wire or as a ninth bit.

Pixels arrive on a ready/valid stream. They are either 32-bit XRGB8888 words, which are converted to RGB565, or RGB565 words, which pass through. An optional swap sends the low byte of each pixel first. Each byte also carries a rate flag. The flag asks for the slow command rate on short transfers and the full link rate on long pixel bursts. A blank request fills the whole panel with black without reading the pixel stream. While the output is disabled, requests are accepted and dropped, and the bus stays quiet.

Top module: `dwin_seq`

## Requirements
- R1: After an accepted request, the output bytes are 0x2A, four parameters, 0x2B, four parameters, 0x2C, then the payload. Only the three command bytes carry `out_dc`=0. Every parameter and payload byte carries `out_dc`=1.
- R2: Each window command's four parameters are: the start coordinate's high byte, then its low byte, then the high byte of (end−1), then the low byte of (end−1). Coordinates are zero-extended to 16 bits. The column command uses x and the row command uses y.
- R3: The payload is exactly (x2−x1)·(y2−y1)·2 bytes. `busy` rises in the cycle after acceptance and falls in the cycle after the last payload byte is accepted.
- R4: With `fmt_xrgb`=0 a pixel is `pix_data[15:0]`. Without swap, its high byte is sent first.
- R5: With `fmt_xrgb`=1 the 16-bit pixel is {`pix_data[23:19]`, `pix_data[15:10]`, `pix_data[7:3]`}.
- R6: With `swap_en`=1 the low byte of each 16-bit pixel is sent before the high byte.
- R7: `out_slow` is 1 on every command and parameter byte. On payload bytes it is 1 when the payload is 64 bytes or fewer, and 0 when it is longer.
- R8: With `enable`=0, an idle request is consumed with no effect: `busy`, `out_valid` and `pix_ready` stay 0.
- R9: A request with `req_blank`=1 writes the window 0..PANEL_W−1 by 0..PANEL_H−1 with all-zero payload bytes. It ignores the rectangle inputs and never asserts `pix_ready`.
- R10: The rectangle, format, swap and blank inputs are captured when the request is accepted. Changing them while `busy` is high has no effect on the stream.
- R11: When a byte is offered and `out_ready` is low, the same byte, flag and rate stay offered in the next cycle.
- R12: After reset `busy`, `out_valid` and `pix_ready` are 0. A request is accepted when `req_valid` is 1 and `busy` is 0.
- R13: A pixel is consumed (`pix_ready`=1) only in the cycle its second byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Output enabled; when 0, requests are dropped |
| req_valid | input | 1 | Update request strobe, taken when not busy |
| req_blank | input | 1 | Request is a full-panel blank |
| req_x1 | input | CW | First column, inclusive |
| req_y1 | input | CW | First row, inclusive |
| req_x2 | input | CW | Column end, exclusive |
| req_y2 | input | CW | Row end, exclusive |
| fmt_xrgb | input | 1 | Pixel input is XRGB8888 (1) or RGB565 (0) |
| swap_en | input | 1 | Send the low byte of each pixel first |
| busy | output | 1 | An update is in progress |
| pix_valid | input | 1 | Pixel word available |
| pix_data | input | 32 | Pixel word |
| pix_ready | output | 1 | Pixel word consumed |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_dc | output | 1 | 0 for a command byte, 1 for parameter or pixel data |
| out_slow | output | 1 | Byte belongs to a short transfer run at the reduced rate |

## Verification
Rectangles are swept in combination with both input formats and both byte orders. The rectangles are a single pixel, small interior windows, and a window with coordinates above 255, which tells apart the high and low parameter bytes. Payloads of exactly 64 and 66 bytes sit on either side of the rate threshold. Downstream back-pressure alternates with free-running acceptance, which separates byte holding from byte advancing. The remaining cases are blank requests, requests while the output is disabled, and input changes during a busy update.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PIX  = 2'd2
  } dwin_state_t;

  localparam logic [7:0] CMD_COLWIN = 8'h2A;
  localparam logic [7:0] CMD_ROWWIN = 8'h2B;
  localparam logic [7:0] CMD_MEMWR  = 8'h2C;
  localparam int         HDR_LEN    = 11;
  localparam int         SLOW_MAX_BYTES = 64;
endpackage

// File: rtl/dwin_hdr.sv
module dwin_hdr
  import dwin_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [3:0]    idx,
  input  logic [CW-1:0] col_first,
  input  logic [CW-1:0] col_last,
  input  logic [CW-1:0] row_first,
  input  logic [CW-1:0] row_last,
  output logic [7:0]    hdr_byte,
  output logic          hdr_is_cmd
);
  logic [15:0] cf_w, cl_w, rf_w, rl_w;

  assign cf_w = 16'(col_first);
  assign cl_w = 16'(col_last);
  assign rf_w = 16'(row_first);
  assign rl_w = 16'(row_last);

  always_comb begin
    hdr_is_cmd = 1'b0;
    case (idx)
      4'd0:    begin hdr_byte = CMD_COLWIN; hdr_is_cmd = 1'b1; end
      4'd1:    hdr_byte = cf_w[15:8];
      4'd2:    hdr_byte = cf_w[7:0];
      4'd3:    hdr_byte = cl_w[15:8];
      4'd4:    hdr_byte = cl_w[7:0];
      4'd5:    begin hdr_byte = CMD_ROWWIN; hdr_is_cmd = 1'b1; end
      4'd6:    hdr_byte = rf_w[15:8];
      4'd7:    hdr_byte = rf_w[7:0];
      4'd8:    hdr_byte = rl_w[15:8];
      4'd9:    hdr_byte = rl_w[7:0];
      4'd10:   begin hdr_byte = CMD_MEMWR; hdr_is_cmd = 1'b1; end
      default: hdr_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/dwin_pixfmt.sv
module dwin_pixfmt (
  input  logic [31:0] word,
  input  logic        is_xrgb,
  input  logic        swap,
  input  logic        second,
  input  logic        zero,
  output logic [7:0]  byte_out
);
  logic [15:0] px565;
  logic        take_low;

  assign px565    = is_xrgb ? {word[23:19], word[15:10], word[7:3]} : word[15:0];
  assign take_low = second ^ swap;

  always_comb begin
    if (zero)          byte_out = 8'h00;
    else if (take_low) byte_out = px565[7:0];
    else               byte_out = px565[15:8];
  end
endmodule

// File: rtl/dwin_seq.sv
module dwin_seq
  import dwin_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PANEL_W = 240,
  parameter int PANEL_H = 320
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          req_valid,
  input  logic          req_blank,
  input  logic [CW-1:0] req_x1,
  input  logic [CW-1:0] req_y1,
  input  logic [CW-1:0] req_x2,
  input  logic [CW-1:0] req_y2,
  input  logic          fmt_xrgb,
  input  logic          swap_en,
  output logic          busy,
  input  logic          pix_valid,
  input  logic [31:0]   pix_data,
  output logic          pix_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_dc,
  output logic          out_slow
);
  localparam int PW = 2 * CW;
  localparam logic [CW-1:0] BLK_XE  = CW'(PANEL_W - 1);
  localparam logic [CW-1:0] BLK_YE  = CW'(PANEL_H - 1);
  localparam logic [PW-1:0] BLK_CNT = PW'(PANEL_W * PANEL_H);
  localparam logic [PW-1:0] SLOW_PIX = PW'(SLOW_MAX_BYTES / 2);
  localparam logic [3:0]    HDR_LAST = 4'(HDR_LEN - 1);

  dwin_state_t st_q, st_d;
  logic [3:0]    idx_q, idx_d;
  logic          sel_q, sel_d;
  logic [PW-1:0] left_q, left_d;
  logic [CW-1:0] xs_q, xe_q, ys_q, ye_q;
  logic [CW-1:0] xs_d, xe_d, ys_d, ye_d;
  logic          blank_q, fmt_q, swap_q, fast_q;
  logic          blank_d, fmt_d, swap_d, fast_d;
  logic          accept, xfer;
  logic [CW-1:0] w_req, h_req;
  logic [PW-1:0] cnt_req;
  logic [7:0]    hdr_byte, pix_byte;
  logic          hdr_is_cmd;

  assign accept  = req_valid && (st_q == ST_IDLE);
  assign w_req   = req_x2 - req_x1;
  assign h_req   = req_y2 - req_y1;
  assign cnt_req = PW'(w_req) * PW'(h_req);
  assign xfer    = out_valid && out_ready;

  dwin_hdr #(.CW(CW)) u_hdr (
    .idx        (idx_q),
    .col_first  (xs_q),
    .col_last   (xe_q),
    .row_first  (ys_q),
    .row_last   (ye_q),
    .hdr_byte   (hdr_byte),
    .hdr_is_cmd (hdr_is_cmd)
  );

  dwin_pixfmt u_fmt (
    .word     (pix_data),
    .is_xrgb  (fmt_q),
    .swap     (swap_q),
    .second   (sel_q),
    .zero     (blank_q),
    .byte_out (pix_byte)
  );

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_dc    = 1'b1;
    out_slow  = 1'b1;
    pix_ready = 1'b0;
    case (st_q)
      ST_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_byte;
        out_dc    = !hdr_is_cmd;
      end
      ST_PIX: begin
        out_valid = blank_q || pix_valid;
        out_data  = pix_byte;
        out_slow  = !fast_q;
        pix_ready = !blank_q && sel_q && pix_valid && out_ready;
      end
      default: ;
    endcase
  end

  assign busy = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q; idx_d = idx_q; sel_d = sel_q; left_d = left_q;
    xs_d = xs_q; xe_d = xe_q; ys_d = ys_q; ye_d = ye_q;
    blank_d = blank_q; fmt_d = fmt_q; swap_d = swap_q; fast_d = fast_q;
    case (st_q)
      ST_IDLE: begin
        if (accept && enable) begin
          st_d    = ST_HDR;
          idx_d   = 4'd0;
          sel_d   = 1'b0;
          blank_d = req_blank;
          fmt_d   = fmt_xrgb;
          swap_d  = swap_en;
          if (req_blank) begin
            xs_d = '0; xe_d = BLK_XE; ys_d = '0; ye_d = BLK_YE;
            left_d = BLK_CNT;
          end else begin
            xs_d = req_x1; xe_d = req_x2 - 1'b1;
            ys_d = req_y1; ye_d = req_y2 - 1'b1;
            left_d = cnt_req;
          end
          fast_d = (req_blank ? BLK_CNT : cnt_req) > SLOW_PIX;
        end
      end
      ST_HDR: begin
        if (xfer) begin
          idx_d = idx_q + 4'd1;
          if (idx_q == HDR_LAST) st_d = ST_PIX;
        end
      end
      ST_PIX: begin
        if (xfer) begin
          sel_d = !sel_q;
          if (sel_q) begin
            left_d = left_q - 1'b1;
            if (left_q == PW'(1)) st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; sel_q <= 1'b0; left_q <= '0;
      xs_q <= '0; xe_q <= '0; ys_q <= '0; ye_q <= '0;
      blank_q <= 1'b0; fmt_q <= 1'b0; swap_q <= 1'b0; fast_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; sel_q <= sel_d; left_q <= left_d;
      xs_q <= xs_d; xe_q <= xe_d; ys_q <= ys_d; ye_q <= ye_d;
      blank_q <= blank_d; fmt_q <= fmt_d; swap_q <= swap_d; fast_q <= fast_d;
    end
  end

  // R12: nothing leaves or enters while idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !pix_ready));

  // R8: a request while disabled leaves the block idle
  p_drop_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy && req_valid) |=> !busy);

  // R11: a refused byte is held unchanged
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_dc) && $stable(out_slow)));

  // R3: busy only ends after an accepted data byte
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready && out_dc));

  // R7: command bytes always use the slow rate
  p_cmd_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dc) |-> out_slow);

  // R13: a pixel is consumed only together with an accepted byte
  p_pix_pair_r13: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (out_valid && out_ready && out_dc));
endmodule

// File: tb/dwin_seq_test.sv
module dwin_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int PW_ = 8;
  localparam int PH_ = 4;

  logic clk, rst_n, enable, req_valid, req_blank;
  logic [CW-1:0] req_x1, req_y1, req_x2, req_y2;
  logic fmt_xrgb, swap_en, busy, pix_valid, pix_ready;
  logic [31:0] pix_data;
  logic out_valid, out_ready, out_dc, out_slow;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  dwin_seq #(.CW(CW), .PANEL_W(PW_), .PANEL_H(PH_)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid),
    .req_blank(req_blank), .req_x1(req_x1), .req_y1(req_y1),
    .req_x2(req_x2), .req_y2(req_y2), .fmt_xrgb(fmt_xrgb), .swap_en(swap_en),
    .busy(busy), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_dc(out_dc), .out_slow(out_slow)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_pix(input int p);
    gen_pix = {8'hA5, 8'(p*29+3), 8'(p*71+17), 8'(p*13+200)};
  endfunction

  function automatic logic [7:0] hdr_exp(input int i, input int xs, input int xe,
                                         input int ys, input int ye);
    case (i)
      0: hdr_exp = 8'h2A;
      1: hdr_exp = 8'(xs >> 8);
      2: hdr_exp = 8'(xs);
      3: hdr_exp = 8'(xe >> 8);
      4: hdr_exp = 8'(xe);
      5: hdr_exp = 8'h2B;
      6: hdr_exp = 8'(ys >> 8);
      7: hdr_exp = 8'(ys);
      8: hdr_exp = 8'(ye >> 8);
      9: hdr_exp = 8'(ye);
      default: hdr_exp = 8'h2C;
    endcase
  endfunction

  task automatic run(input int x1, input int y1, input int x2, input int y2,
                     input bit fx, input bit sw, input bit blk, input int rmode);
    int xs, xe, ys, ye, npix, total, n, k, cyc;
    bit stall_seen;
    logic [7:0] st_d; logic st_dc, st_sl;
    logic [15:0] px; logic [31:0] w; logic [7:0] eb; bit edc, esl;
    if (blk) begin xs = 0; xe = PW_-1; ys = 0; ye = PH_-1; npix = PW_*PH_; end
    else begin xs = x1; xe = x2-1; ys = y1; ye = y2-1; npix = (x2-x1)*(y2-y1); end
    total = 11 + 2*npix;
    @(negedge clk);
    req_valid = 1; req_blank = blk; req_x1 = CW'(x1); req_y1 = CW'(y1);
    req_x2 = CW'(x2); req_y2 = CW'(y2); fmt_xrgb = fx; swap_en = sw;
    out_ready = 0; pix_valid = 0;
    @(negedge clk);
    req_valid = 0;
    // R10: scramble captured inputs while busy
    req_blank = !blk; req_x1 = 7; req_y1 = 1; req_x2 = 9; req_y2 = 2;
    fmt_xrgb = !fx; swap_en = !sw;
    check(busy === 1'b1, "R3 busy rises", busy, 1);
    n = 0; k = 0; cyc = 0; stall_seen = 0;
    while (n < total && cyc < 2000) begin
      out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      pix_valid = !blk;
      pix_data = gen_pix(k);
      #1;
      if (stall_seen) begin
        check(out_valid && out_data == st_d && out_dc == st_dc && out_slow == st_sl,
              "R11 held byte", out_data, st_d);
        stall_seen = 0;
      end
      if (blk) check(pix_ready === 1'b0, "R9 no pixel read", pix_ready, 0);
      if (out_valid && out_ready) begin
        if (n < 11) begin
          eb = hdr_exp(n, xs, xe, ys, ye);
          edc = !(n == 0 || n == 5 || n == 10);
          esl = 1;
        end else begin
          w = blk ? 32'h0 : gen_pix((n-11)/2);
          px = fx ? {w[23:19], w[15:10], w[7:3]} : w[15:0];
          eb = ((((n-11) % 2) == 1) ^ sw) ? px[7:0] : px[15:8];
          if (blk) eb = 8'h00;
          edc = 1;
          esl = (2*npix <= 64);
        end
        check(out_data == eb, (n < 11) ? "R1 R2 header byte" :
              (blk ? "R9 blank byte" : (fx ? "R5 R6 xrgb byte" : "R4 R6 565 byte")),
              out_data, eb);
        check(out_dc == edc, "R1 dc flag", out_dc, edc);
        check(out_slow == esl, "R7 rate flag", out_slow, esl);
        if (pix_ready) check(((n-11) % 2) == 1, "R13 consume on second byte", n, 0);
        n++;
      end else if (out_valid && !out_ready) begin
        stall_seen = 1; st_d = out_data; st_dc = out_dc; st_sl = out_sl_f(out_slow);
      end
      if (pix_ready) k++;
      @(negedge clk);
      cyc++;
      if (n < total) check(busy === 1'b1, "R3 busy during update", busy, 1);
    end
    out_ready = 0; pix_valid = 0;
    #1;
    check(n == total, "R3 byte count", n, total);
    check(busy === 1'b0, "R3 busy falls after last byte", busy, 0);
    check(out_valid === 1'b0, "R3 no extra byte", out_valid, 0);
    if (!blk) check(k == npix, "R13 pixels consumed", k, npix);
  endtask

  function automatic logic out_sl_f(input logic v);
    out_sl_f = v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 1; req_valid = 0; req_blank = 0;
    req_x1 = 0; req_y1 = 0; req_x2 = 0; req_y2 = 0;
    fmt_xrgb = 0; swap_en = 0; pix_valid = 0; pix_data = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0 && out_valid === 1'b0 && pix_ready === 1'b0,
          "R12 reset state", {busy, out_valid, pix_ready}, 0);
    rst_n = 1;
    @(negedge clk);

    // R8: disabled output drops the request
    enable = 0;
    req_valid = 1; req_x1 = 1; req_y1 = 1; req_x2 = 3; req_y2 = 3;
    out_ready = 1; pix_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      check(busy === 1'b0 && out_valid === 1'b0 && pix_ready === 1'b0,
            "R8 disabled drop", {busy, out_valid, pix_ready}, 0);
      @(negedge clk);
    end
    enable = 1;

    for (int r = 0; r < 5; r++) begin
      for (int m = 0; m < 4; m++) begin
        case (r)
          0: run(0, 0, 1, 1, m[0], m[1], 0, m % 2);
          1: run(3, 2, 5, 4, m[0], m[1], 0, (m+1) % 2);
          2: run(1, 0, 12, 3, m[0], m[1], 0, m % 2);       // R7: 66 bytes
          3: run(0, 0, 4, 8, m[0], m[1], 0, (m+1) % 2);    // R7: 64 bytes
          default: run(250, 300, 260, 303, m[0], m[1], 0, m % 2); // R2 high bytes
        endcase
      end
    end
    run(5, 5, 6, 6, 0, 0, 1, 0);  // R9 blank, 64 bytes
    run(5, 5, 6, 6, 1, 1, 1, 1);  // R9 blank under back-pressure

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule